// File: doc/BRIEF.md
# Sticky Pin Capture with Acknowledge

This block sits between a group of input pins and the register a core reads them through. Each pin has a held bit. Any cycle in which the pin is high sets that bit, so a pulse lasting one cycle from a peripheral cell is kept until software acknowledges it. A view mask with one bit per pin chooses what the core sees for each bit. A clear view bit shows the live pin. A set view bit shows the live pin ORed with its held bit, combinationally, with no lag of a cycle.

Software writes the whole view mask with a strobe and a data word. It acknowledges held bits with a strobe and a bit mask. Acknowledging does not force a bit to zero. It reloads each selected held bit from the live pin level, so a pin that is still high keeps its bit set. Each core has its own instance, so an acknowledge by one core leaves the held bits seen by every other core untouched. A second pin group is handled by a second instance.

The asynchronous active-low reset is asserted at once and released through a short synchronizer inside the block.

Top module: `stky_capture`

## Requirements
- R1: A high on a pin sets its held bit at the next clock edge, whatever value its view bit has.
- R2: When a view bit is 0, the visible bit equals the live pin in the same cycle.
- R3: When a view bit is 1, the visible bit is the live pin ORed with the held bit in the same cycle, so a rising pin is visible with no delay.
- R4: A view-mask write strobe loads the whole mask from the data word at the clock edge. The new mask governs the visible value from the next cycle on, and the mask keeps its value while the strobe is low.
- R5: An acknowledge strobe reloads each held bit whose acknowledge-mask bit is 1 from the live pin level: the bit clears if the pin is low and stays set if the pin is high.
- R6: Held bits outside the acknowledge mask, and all held bits when the acknowledge strobe is low, keep their value and still collect new pin highs.
- R7: When a pin is high in the same cycle as an acknowledge that selects its bit, the held bit is set after that edge.
- R8: While reset is asserted, and after it is released until the first write, the held bits and the view mask are all zero, so every visible bit equals its live pin. Mask writes made during reset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pins_i | input | WIDTH | Live pin levels, already synchronised |
| view_wr_i | input | 1 | View-mask write strobe |
| view_data_i | input | WIDTH | New view mask; 1 selects the held view for that bit |
| ack_i | input | 1 | Acknowledge strobe |
| ack_mask_i | input | WIDTH | Bits that the acknowledge reloads from the pins |
| vis_o | output | WIDTH | Visible input value for the core |

## Verification
An acknowledge of a bit can fall in the same cycle as a new high on that bit's pin. A view-mask write can also fall in the same cycle as an acknowledge. The bench drives each of these collisions on purpose in directed steps. It then repeats them many times under random pins, random acknowledge masks and random mask writes. A behavioural model of the held bits and the mask predicts the visible word for every cycle, and that prediction is compared with the output before each clock edge. The held result of a collision shows up through the visible output once the bit's view bit is set.

// File: rtl/stky_pkg.sv
package stky_pkg;

  // Per-bit view selection
  typedef enum logic {
    VIEW_RAW  = 1'b0,
    VIEW_HELD = 1'b1
  } view_e;

  // Visible bit for a given view mode
  function automatic logic view_bit(input view_e mode, input logic pin, input logic held);
    logic res;
    if (mode == VIEW_HELD) res = pin | held;
    else                   res = pin;
    return res;
  endfunction

  // Held-bit next state: an acknowledged bit reloads from the pin,
  // any other bit keeps its value and collects pin highs.
  function automatic logic held_next(input logic held, input logic pin, input logic reload);
    logic res;
    if (reload) res = pin;
    else        res = held | pin;
    return res;
  endfunction

endpackage

// File: rtl/stky_rst_sync.sv
module stky_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sync_no = chain_q[STAGES-1];

endmodule

// File: rtl/stky_view_reg.sv
module stky_view_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] view_o
);

  logic [WIDTH-1:0] view_q;
  logic [WIDTH-1:0] view_d;
  logic             view_en;

  always_comb begin
    view_en = wr_i;
    view_d  = data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      view_q <= '0;
    else if (view_en) view_q <= view_d;
  end

  assign view_o = view_q;

  AST_VIEW_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (view_q == $past(data_i))); // R4

  AST_VIEW_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(view_q)); // R4

endmodule

// File: rtl/stky_bit_cell.sv
module stky_bit_cell
  import stky_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic ack_i,
  input  logic ack_sel_i,
  input  logic view_i,
  output logic vis_o
);

  logic  held_q;
  logic  held_d;
  logic  reload;
  view_e mode;

  always_comb begin
    reload = ack_i & ack_sel_i;
    held_d = held_next(held_q, pin_i, reload);
    mode   = view_e'(view_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= 1'b0;
    else         held_q <= held_d;
  end

  assign vis_o = view_bit(mode, pin_i, held_q);

  AST_PIN_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_i |=> held_q); // R1

  AST_ACK_LOW_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && ack_sel_i && !pin_i) |=> !held_q); // R5

  AST_HELD_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_q && !(ack_i && ack_sel_i)) |=> held_q); // R6

endmodule

// File: rtl/stky_capture.sv
module stky_capture #(
  parameter int unsigned WIDTH       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pins_i,
  input  logic             view_wr_i,
  input  logic [WIDTH-1:0] view_data_i,
  input  logic             ack_i,
  input  logic [WIDTH-1:0] ack_mask_i,
  output logic [WIDTH-1:0] vis_o
);

  localparam int unsigned LAST_BIT = WIDTH - 1;

  logic               rst_int_n;
  logic [LAST_BIT:0]  view_mask;
  logic [LAST_BIT:0]  vis_bits;

  stky_rst_sync #(
    .STAGES(SYNC_STAGES)
  ) u_rst_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_int_n)
  );

  stky_view_reg #(
    .WIDTH(WIDTH)
  ) u_view_reg (
    .clk_i (clk_i),
    .rst_ni(rst_int_n),
    .wr_i  (view_wr_i),
    .data_i(view_data_i),
    .view_o(view_mask)
  );

  for (genvar b = 0; b < WIDTH; b++) begin : g_cell
    stky_bit_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_int_n),
      .pin_i    (pins_i[b]),
      .ack_i    (ack_i),
      .ack_sel_i(ack_mask_i[b]),
      .view_i   (view_mask[b]),
      .vis_o    (vis_bits[b])
    );
  end

  assign vis_o = vis_bits;

  AST_PIN_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    ((pins_i & ~vis_o) == '0)); // R3

  AST_RAW_VIEW: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    ((~view_mask & (vis_o ^ pins_i)) == '0)); // R2

  AST_RESET_RAW: assert property (@(posedge clk_i)
    !rst_int_n |-> (vis_o == pins_i)); // R8

endmodule

// File: tb/stky_capture_tb_top.sv
module stky_capture_tb_top;

  localparam int W = 32;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] pins;
  logic         view_wr;
  logic [W-1:0] view_data;
  logic         ack;
  logic [W-1:0] ack_mask;
  logic [W-1:0] vis;

  int n_checks = 0;
  int n_bad    = 0;
  int cycles   = 0;

  // behavioural reference state
  logic [W-1:0] m_held = '0;
  logic [W-1:0] m_view = '0;

  stky_capture #(.WIDTH(W)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .pins_i     (pins),
    .view_wr_i  (view_wr),
    .view_data_i(view_data),
    .ack_i      (ack),
    .ack_mask_i (ack_mask),
    .vis_o      (vis)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  task automatic check_vis(input logic [W-1:0] exp, input string tag);
    n_checks++;
    if (vis !== exp) begin
      n_bad++;
      $display("FAIL %s: vis actual=%h expected=%h", tag, vis, exp);
    end
  endtask

  // One cycle: drive at negedge, compare before posedge, advance model
  task automatic step(input logic [W-1:0] p, input logic wr, input logic [W-1:0] wd,
                      input logic a, input logic [W-1:0] am, input string tag);
    @(negedge clk);
    pins = p; view_wr = wr; view_data = wd; ack = a; ack_mask = am;
    #2;
    check_vis(p | (m_held & m_view), tag);
    if (a) m_held = (m_held & ~am) | (p & am);
    m_held = m_held | p;
    if (wr) m_view = wd;
  endtask

  // Reset phase: outputs follow pins, writes ignored
  task automatic reset_step(input logic [W-1:0] p, input string tag);
    @(negedge clk);
    pins = p; view_wr = 1'b1; view_data = '1; ack = 1'b0; ack_mask = '0;
    #2;
    check_vis(p, tag);
  endtask

  initial begin
    rst_n = 1'b0; pins = '0; view_wr = 1'b0; view_data = '0; ack = 1'b0; ack_mask = '0;
    for (int i = 0; i < 4; i++) reset_step($urandom, "R8 reset");
    @(negedge clk);
    pins = '0; view_wr = 1'b0; view_data = '0;
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step('0, 1'b0, '0, 1'b0, '0, "R8 release");
    // mask and held bits must be clear: pins show raw
    step(32'hA5A5_0F0F, 1'b0, '0, 1'b0, '0, "R8 post-reset raw");
    step('0, 1'b0, '0, 1'b0, '0, "R2 raw view after pulse");
    // R2: raw view follows pins on both edges
    step(32'h0000_0008, 1'b0, '0, 1'b0, '0, "R2 raw high");
    step('0, 1'b0, '0, 1'b0, '0, "R2 raw low");
    // R1 and R4: held set with raw view; new mask applies next cycle
    step('0, 1'b1, 32'h0000_0008, 1'b0, '0, "R4 write cycle still old mask");
    step('0, 1'b0, '0, 1'b0, '0, "R1 held bit visible after mask write");
    // R5: acknowledge with pin low clears
    step('0, 1'b0, '0, 1'b1, 32'h0000_0008, "R5 ack cycle");
    step('0, 1'b0, '0, 1'b0, '0, "R5 cleared after ack with pin low");
    // R3: rising pin with held view shows at once, then held
    step(32'h0000_0008, 1'b0, '0, 1'b0, '0, "R3 no lag");
    step('0, 1'b0, '0, 1'b0, '0, "R3 held after fall");
    // R5: acknowledge with pin high keeps it set
    step(32'h0000_0008, 1'b0, '0, 1'b1, 32'h0000_0008, "R5 ack pin high");
    step('0, 1'b0, '0, 1'b0, '0, "R5 stays set");
    // R6: ack of other bits and ack mask with strobe low leave it alone
    step(32'h0000_0010, 1'b1, 32'h0000_0018, 1'b1, 32'hFFFF_FFF7, "R6 ack others");
    step('0, 1'b0, '0, 1'b0, 32'hFFFF_FFFF, "R6 mask without strobe");
    step('0, 1'b0, '0, 1'b0, '0, "R6 held kept");
    // R7: pin high in same cycle as ack of its bit
    step(32'h0000_0010, 1'b0, '0, 1'b1, 32'h0000_0018, "R7 collide");
    step('0, 1'b0, '0, 1'b0, '0, "R7 bit set after collision");
    // R4 with ack in same cycle: whole mask replaced
    step('0, 1'b1, 32'hFFFF_0000, 1'b1, 32'h0000_00FF, "R4 write with ack");
    step(32'h0001_0000, 1'b0, '0, 1'b0, '0, "R4 new mask");
    step('0, 1'b0, '0, 1'b0, '0, "R4 held upper bit");
    // randomized collisions
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] rp;
      rp = $urandom & $urandom;
      step(rp, ($urandom % 8) == 0, $urandom, ($urandom % 3) == 0, $urandom, "R3 R7 random");
    end
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule